// File: doc/BRIEF.md
# Four-Way Fetch Translation Buffer with Pairwise LRU

This block translates instruction fetch addresses through four fully associative translation entries. Each request carries a virtual address, an address-space identifier, the processor's privilege level and the single-virtual-space mode flag. All four entries are compared in parallel. Exactly one match returns a hit with the entry index and the physical address. Two or more matches return a multiple-hit error. No match starts a refill exchange with the larger unified translation buffer.

If the unified buffer supplies a translation, it is copied into a victim slot and reported as a hit. The victim slot is chosen by a six-bit pairwise recency state, which is exposed as the top six bits of the MMU control word. Every use of an entry, whether a hit or a refill, updates that state with fixed per-entry clear and set masks. Four page sizes are supported: 1 KiB, 4 KiB, 64 KiB and 1 MiB.

Top module: `itlb4_fetch`

## Requirements
- R1: After reset no entry is valid, `lru_bits` is 0, `req_ready` is 1, and `res_valid` and `refill_req` are 0.
- R2: A request accepted in idle state, with exactly one matching valid entry, gives `res_valid`=1 and `res_hit`=1 one cycle later. The result carries that entry's index and a physical address built from the entry's page number above the page offset and the request address within it. Size code 0/1/2/3 selects an offset of 10/12/16/20 bits.
- R3: The identifier compare is bypassed for an entry whose shared bit is 1. It is also bypassed for every entry when both `priv_mode` and `sv_mode` are 1. Otherwise a stored identifier must equal `req_asid` for the entry to match.
- R4: Two or more matching entries give `res_multi`=1 with `res_hit`=0 and `res_miss`=0. Whenever `res_valid` is 1, exactly one of the three outcome flags is set.
- R5: When no entry matches, `refill_req` rises one cycle after the request. It holds with `refill_vaddr` and `refill_asid` stable until `refill_ack`, and `req_ready` stays 0 throughout.
- R6: A `refill_ack` with `refill_found`=1 writes the supplied translation, marked valid, into the victim slot. One cycle later it returns `res_hit` with the victim index and the translated address.
- R7: A `refill_ack` with `refill_found`=0 returns `res_miss`=1 and leaves all entries unchanged.
- R8: Each use of entry k updates `lru_bits`[5:0] (control bits 31:26) as follows. k=0 clears bits 5..3. k=1 clears bits 2..1 and sets bit 5. k=2 clears bit 0 and sets bits 4 and 2. k=3 sets bits 3, 1 and 0.
- R9: The victim is chosen in priority order. Entry 0 is chosen when bits 5..3 are all 1. Otherwise entry 1 when bit 5 is 0 and bits 2 and 1 are 1. Otherwise entry 2 when bits 4 and 2 are 0 and bit 0 is 1. Otherwise entry 3.
- R10: A multiple-hit or miss outcome leaves `lru_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch translation request |
| req_vaddr | input | 32 | Fetch virtual address |
| req_asid | input | 8 | Current address-space identifier |
| priv_mode | input | 1 | Processor is privileged |
| sv_mode | input | 1 | Single-virtual-space mode enabled |
| req_ready | output | 1 | Block can accept a request |
| refill_req | output | 1 | Asking the unified buffer for a translation |
| refill_vaddr | output | 32 | Address that missed |
| refill_asid | output | 8 | Identifier of the missed request |
| refill_ack | input | 1 | Unified buffer answer is present |
| refill_found | input | 1 | Unified buffer had a translation |
| refill_vpn | input | 22 | Supplied virtual page number |
| refill_ppn | input | 19 | Supplied physical page number |
| refill_size | input | 2 | Supplied page size code |
| refill_shared | input | 1 | Supplied shared bit |
| refill_ent_asid | input | 8 | Supplied entry identifier |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | Translation absent in both buffers |
| res_multi | output | 1 | Multiple matching entries |
| res_index | output | 2 | Entry index of the hit |
| res_paddr | output | 29 | Translated physical address |
| lru_bits | output | 6 | Recency state, control word bits 31:26 |

## Verification
Directed fetches come first. A cold miss checks that reset selects slot 3 as the victim. A repeat of the same address turns that miss into a hit. An unmapped address exercises the refill-absent path. A one-megabyte shared-space page that overlaps a four-kilobyte page yields a multiple hit only when the privileged single-space bypass is active, and an identifier-specific hit otherwise.

The random phase then mixes eight unified translations of all four sizes, several identifiers, privilege and mode settings, and off-page addresses. This drives the recency state through the full victim rotation, where a wrong mask or a wrong decode priority shows up as a wrong victim index. The mixed sizes separate offset-width errors in the address composition.

// File: rtl/itlb4_pkg.sv
package itlb4_pkg;
   localparam int VA_W   = 32;
   localparam int PA_W   = 29;
   localparam int PG_LSB = 10;
   localparam int ASID_W = 8;
   localparam int VPN_W  = VA_W - PG_LSB;
   localparam int PPN_W  = PA_W - PG_LSB;

   typedef logic [1:0] pgsz_t;

   typedef struct packed {
      logic              v;
      logic              sh;
      pgsz_t             sz;
      logic [ASID_W-1:0] asid;
      logic [VPN_W-1:0]  vpn;
      logic [PPN_W-1:0]  ppn;
   } tlb_ent_t;

   // extra offset bits beyond the smallest page for each size code
   function automatic int unsigned pg_extra(pgsz_t s);
      case (s)
         2'd0:    return 0;
         2'd1:    return 2;
         2'd2:    return 6;
         default: return 10;
      endcase
   endfunction

   function automatic logic [VPN_W-1:0] vpn_mask(pgsz_t s);
      return {VPN_W{1'b1}} << pg_extra(s);
   endfunction

   function automatic logic [PA_W-1:0] make_pa(logic [PPN_W-1:0] ppn, pgsz_t s,
                                               logic [PA_W-1:0] va);
      logic [PA_W-1:0] off;
      off = ~({PA_W{1'b1}} << (PG_LSB + pg_extra(s)));
      return ({ppn, {PG_LSB{1'b0}}} & ~off) | (va & off);
   endfunction
endpackage

// File: rtl/itlb4_match.sv
module itlb4_match
   import itlb4_pkg::*;
(
   input  logic              e_v,
   input  logic              e_sh,
   input  pgsz_t             e_sz,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   input  logic              asid_bypass,
   output logic              hit
);
   logic id_ok;
   logic pg_ok;

   always_comb begin
      id_ok = e_sh | asid_bypass | (e_asid == q_asid);
      pg_ok = ((e_vpn ^ q_vpn) & vpn_mask(e_sz)) == '0;
      hit   = e_v & id_ok & pg_ok;
   end
endmodule

// File: rtl/itlb4_lru.sv
module itlb4_lru #(
   parameter int N_WAY = 4,
   parameter int ST_W  = 6,
   localparam int IDX_W = $clog2(N_WAY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   output logic [ST_W-1:0]  lru_q,
   output logic [IDX_W-1:0] victim
);
   generate
      if (N_WAY != 4 || ST_W != 6) begin : g_bad_cfg
         $error("itlb4_lru: pairwise encoding needs 4 ways and 6 state bits");
      end
   endgenerate

   logic [ST_W-1:0] lru_d;

   always_comb begin
      lru_d = lru_q;
      if (upd_en) begin
         case (upd_idx)
            2'd0: lru_d[5:3] = 3'b000;
            2'd1: begin
               lru_d[2:1] = 2'b00;
               lru_d[5]   = 1'b1;
            end
            2'd2: begin
               lru_d[0] = 1'b0;
               lru_d[4] = 1'b1;
               lru_d[2] = 1'b1;
            end
            default: begin
               lru_d[3] = 1'b1;
               lru_d[1] = 1'b1;
               lru_d[0] = 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      if (lru_q[5:3] == 3'b111)                            victim = 2'd0;
      else if (!lru_q[5] && lru_q[2] && lru_q[1])          victim = 2'd1;
      else if (!lru_q[4] && !lru_q[2] && lru_q[0])         victim = 2'd2;
      else                                                 victim = 2'd3;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lru_q <= '0;
      else        lru_q <= lru_d;
   end

   // the way just used (0..2) never becomes the next victim
   assert_mru_not_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_idx != 2'd3) |=> (victim != $past(upd_idx)));
endmodule

// File: rtl/itlb4_fetch.sv
module itlb4_fetch
   import itlb4_pkg::*;
#(
   parameter int N_ENT = 4,
   parameter int LRU_W = 6,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              priv_mode,
   input  logic              sv_mode,
   output logic              req_ready,
   output logic              refill_req,
   output logic [VA_W-1:0]   refill_vaddr,
   output logic [ASID_W-1:0] refill_asid,
   input  logic              refill_ack,
   input  logic              refill_found,
   input  logic [VPN_W-1:0]  refill_vpn,
   input  logic [PPN_W-1:0]  refill_ppn,
   input  logic [1:0]        refill_size,
   input  logic              refill_shared,
   input  logic [ASID_W-1:0] refill_ent_asid,
   output logic              res_valid,
   output logic              res_hit,
   output logic              res_miss,
   output logic              res_multi,
   output logic [IDX_W-1:0]  res_index,
   output logic [PA_W-1:0]   res_paddr,
   output logic [LRU_W-1:0]  lru_bits
);
   generate
      if (N_ENT != 4) begin : g_bad_ent
         $error("itlb4_fetch: exactly four entries are supported");
      end
   endgenerate

   typedef enum logic {ST_IDLE, ST_FILL} st_t;

   st_t                st_q;
   tlb_ent_t           ent_q [N_ENT];
   logic [N_ENT-1:0]   hits;
   logic [IDX_W-1:0]   first_idx;
   logic [IDX_W:0]     n_hit;
   logic [IDX_W-1:0]   victim;
   logic               upd_en;
   logic [IDX_W-1:0]   upd_idx;
   logic [VA_W-1:0]    miss_va_q;
   logic [ASID_W-1:0]  miss_asid_q;
   logic [VPN_W-1:0]   q_vpn;
   logic               bypass;
   logic               lookup;
   logic               fill_done;

   assign q_vpn     = req_vaddr[VA_W-1:PG_LSB];
   assign bypass    = priv_mode & sv_mode;
   assign lookup    = (st_q == ST_IDLE) & req_valid;
   assign fill_done = (st_q == ST_FILL) & refill_ack;

   generate
      for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
         itlb4_match u_m (
            .e_v        (ent_q[g].v),
            .e_sh       (ent_q[g].sh),
            .e_sz       (ent_q[g].sz),
            .e_asid     (ent_q[g].asid),
            .e_vpn      (ent_q[g].vpn),
            .q_vpn      (q_vpn),
            .q_asid     (req_asid),
            .asid_bypass(bypass),
            .hit        (hits[g])
         );
      end
   endgenerate

   always_comb begin
      first_idx = '0;
      n_hit     = '0;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hits[i]) first_idx = IDX_W'(i);
      end
      for (int i = 0; i < N_ENT; i++) n_hit = n_hit + {{IDX_W{1'b0}}, hits[i]};
   end

   always_comb begin
      upd_en  = 1'b0;
      upd_idx = first_idx;
      if (lookup && n_hit == 1) upd_en = 1'b1;
      else if (fill_done && refill_found) begin
         upd_en  = 1'b1;
         upd_idx = victim;
      end
   end

   itlb4_lru #(.N_WAY(N_ENT), .ST_W(LRU_W)) u_lru (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (upd_en),
      .upd_idx(upd_idx),
      .lru_q  (lru_bits),
      .victim (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         res_valid   <= 1'b0;
         res_hit     <= 1'b0;
         res_miss    <= 1'b0;
         res_multi   <= 1'b0;
         res_index   <= '0;
         res_paddr   <= '0;
         miss_va_q   <= '0;
         miss_asid_q <= '0;
         for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
      end else begin
         res_valid <= 1'b0;
         if (lookup) begin
            if (n_hit == 1) begin
               res_valid <= 1'b1;
               res_hit   <= 1'b1;
               res_miss  <= 1'b0;
               res_multi <= 1'b0;
               res_index <= first_idx;
               res_paddr <= make_pa(ent_q[first_idx].ppn, ent_q[first_idx].sz,
                                    req_vaddr[PA_W-1:0]);
            end else if (n_hit > 1) begin
               res_valid <= 1'b1;
               res_hit   <= 1'b0;
               res_miss  <= 1'b0;
               res_multi <= 1'b1;
               res_index <= first_idx;
               res_paddr <= '0;
            end else begin
               st_q        <= ST_FILL;
               miss_va_q   <= req_vaddr;
               miss_asid_q <= req_asid;
            end
         end else if (fill_done) begin
            st_q      <= ST_IDLE;
            res_valid <= 1'b1;
            res_multi <= 1'b0;
            if (refill_found) begin
               ent_q[victim] <= '{v: 1'b1, sh: refill_shared, sz: refill_size,
                                  asid: refill_ent_asid, vpn: refill_vpn,
                                  ppn: refill_ppn};
               res_hit   <= 1'b1;
               res_miss  <= 1'b0;
               res_index <= victim;
               res_paddr <= make_pa(refill_ppn, refill_size, miss_va_q[PA_W-1:0]);
            end else begin
               res_hit   <= 1'b0;
               res_miss  <= 1'b1;
               res_index <= '0;
               res_paddr <= '0;
            end
         end
      end
   end

   assign req_ready    = (st_q == ST_IDLE);
   assign refill_req   = (st_q == ST_FILL);
   assign refill_vaddr = miss_va_q;
   assign refill_asid  = miss_asid_q;

   assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot({res_hit, res_miss, res_multi}));

   assert_fill_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_req && !refill_ack) |=>
         (refill_req && $stable(refill_vaddr) && $stable(refill_asid)));

   assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req |-> !req_ready);

   assert_lru_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (lru_bits == $past(lru_bits)));
endmodule

// File: tb/sim_itlb4_fetch.sv
`timescale 1ns/1ps
module sim_itlb4_fetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [7:0]  req_asid = '0;
   logic        priv_mode = 1'b0, sv_mode = 1'b0;
   logic        req_ready, refill_req;
   logic [31:0] refill_vaddr;
   logic [7:0]  refill_asid;
   logic        refill_ack = 1'b0, refill_found = 1'b0;
   logic [21:0] refill_vpn = '0;
   logic [18:0] refill_ppn = '0;
   logic [1:0]  refill_size = '0;
   logic        refill_shared = 1'b0;
   logic [7:0]  refill_ent_asid = '0;
   logic        res_valid, res_hit, res_miss, res_multi;
   logic [1:0]  res_index;
   logic [28:0] res_paddr;
   logic [5:0]  lru_bits;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   itlb4_fetch u0 (.*);

   // bench model of the fetch buffer
   bit          m_v [4];
   bit          m_sh [4];
   int          m_sz [4];
   int          m_asid [4];
   logic [31:0] m_base [4];
   logic [18:0] m_ppn [4];
   logic [5:0]  m_lru;
   // unified buffer contents
   logic [31:0] u_base [8];
   int          u_sz [8];
   int          u_asid [8];
   bit          u_sh [8];
   logic [18:0] u_ppn [8];

   function automatic logic [31:0] pg_bytes(int sz);
      case (sz)
         0: return 32'h400;
         1: return 32'h1000;
         2: return 32'h10000;
         default: return 32'h100000;
      endcase
   endfunction

   function automatic bit ent_match(logic [31:0] base, int sz, int easid, bit sh,
                                    logic [31:0] va, int asid, bit byp);
      logic [31:0] m;
      m = ~(pg_bytes(sz) - 1);
      return ((va & m) == (base & m)) && (sh || byp || easid == asid);
   endfunction

   function automatic logic [28:0] calc_pa(logic [18:0] ppn, int sz, logic [31:0] va);
      logic [31:0] s, p;
      s = pg_bytes(sz);
      p = ({13'd0, ppn} << 10) & ~(s - 1);
      p = p | (va & (s - 1));
      return p[28:0];
   endfunction

   // R8 masks applied to the top control byte (lru = byte bits 7:2)
   function automatic logic [5:0] lru_next(logic [5:0] l, int k);
      logic [7:0] b;
      b = {l, 2'b00};
      case (k)
         0: b = b & 8'h1F;
         1: b = (b & 8'hE7) | 8'h80;
         2: b = (b & 8'hFB) | 8'h50;
         default: b = b | 8'h2C;
      endcase
      return b[7:2];
   endfunction

   // R9 priority decode on the top control byte
   function automatic int lru_victim(logic [5:0] l);
      logic [7:0] b;
      b = {l, 2'b00};
      if ((b & 8'hE0) == 8'hE0) return 0;
      if ((b & 8'h98) == 8'h18) return 1;
      if ((b & 8'h54) == 8'h04) return 2;
      return 3;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic fetch(logic [31:0] va, int asid, bit pv, bit sv);
      int cnt, idx, ui, vic;
      bit byp;
      byp = pv && sv;
      cnt = 0; idx = 0;
      for (int i = 3; i >= 0; i--)
         if (m_v[i] && ent_match(m_base[i], m_sz[i], m_asid[i], m_sh[i], va, asid, byp)) begin
            cnt++; idx = i;
         end
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_asid = 8'(asid);
      priv_mode = pv; sv_mode = sv;
      @(negedge clk);
      req_valid = 1'b0;
      if (cnt == 1) begin
         chk(res_valid && res_hit, "R2 hit flag", {res_valid, res_hit}, 2'b11);
         chk(res_index == 2'(idx), "R2/R3 index", res_index, idx);
         chk(res_paddr == calc_pa(m_ppn[idx], m_sz[idx], va), "R2 paddr",
             res_paddr, calc_pa(m_ppn[idx], m_sz[idx], va));
         m_lru = lru_next(m_lru, idx);
         chk(lru_bits == m_lru, "R8 lru after hit", lru_bits, m_lru);
      end else if (cnt > 1) begin
         chk(res_valid && res_multi && !res_hit && !res_miss, "R4 multi",
             {res_valid, res_hit, res_miss, res_multi}, 4'b1001);
         chk(lru_bits == m_lru, "R10 lru after multi", lru_bits, m_lru);
      end else begin
         chk(refill_req && !req_ready && !res_valid, "R5 refill start",
             {refill_req, req_ready, res_valid}, 3'b100);
         chk(refill_vaddr == va && refill_asid == 8'(asid), "R5 refill addr",
             refill_vaddr, va);
         @(negedge clk);
         chk(refill_req && refill_vaddr == va && !req_ready, "R5 refill hold",
             refill_vaddr, va);
         ui = -1;
         for (int j = 7; j >= 0; j--)
            if (ent_match(u_base[j], u_sz[j], u_asid[j], u_sh[j], va, asid, byp)) ui = j;
         vic = lru_victim(m_lru);
         refill_ack = 1'b1;
         refill_found = (ui >= 0);
         if (ui >= 0) begin
            refill_vpn = u_base[ui][31:10];
            refill_ppn = u_ppn[ui];
            refill_size = 2'(u_sz[ui]);
            refill_shared = u_sh[ui];
            refill_ent_asid = 8'(u_asid[ui]);
         end
         @(negedge clk);
         refill_ack = 1'b0;
         if (ui >= 0) begin
            chk(res_valid && res_hit, "R6 refill hit", {res_valid, res_hit}, 2'b11);
            chk(res_index == 2'(vic), "R9 victim index", res_index, vic);
            chk(res_paddr == calc_pa(u_ppn[ui], u_sz[ui], va), "R6 refill paddr",
                res_paddr, calc_pa(u_ppn[ui], u_sz[ui], va));
            m_v[vic] = 1; m_sh[vic] = u_sh[ui]; m_sz[vic] = u_sz[ui];
            m_asid[vic] = u_asid[ui]; m_base[vic] = u_base[ui]; m_ppn[vic] = u_ppn[ui];
            m_lru = lru_next(m_lru, vic);
            chk(lru_bits == m_lru, "R8 lru after refill", lru_bits, m_lru);
         end else begin
            chk(res_valid && res_miss && !res_hit, "R7 miss", {res_valid, res_miss}, 2'b11);
            chk(lru_bits == m_lru, "R10 lru after miss", lru_bits, m_lru);
         end
         chk(req_ready && !refill_req, "R5 back to idle", {req_ready, refill_req}, 2'b10);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      u_base[0] = 32'h0000_0000; u_sz[0] = 1; u_asid[0] = 1; u_sh[0] = 0;
      u_base[1] = 32'h0000_1000; u_sz[1] = 0; u_asid[1] = 1; u_sh[1] = 0;
      u_base[2] = 32'h0001_0000; u_sz[2] = 2; u_asid[2] = 2; u_sh[2] = 1;
      u_base[3] = 32'h0010_0000; u_sz[3] = 3; u_asid[3] = 1; u_sh[3] = 0;
      u_base[4] = 32'h0040_0000; u_sz[4] = 1; u_asid[4] = 2; u_sh[4] = 0;
      u_base[5] = 32'h0040_1000; u_sz[5] = 1; u_asid[5] = 3; u_sh[5] = 1;
      u_base[6] = 32'h0000_0000; u_sz[6] = 3; u_asid[6] = 5; u_sh[6] = 0;
      u_base[7] = 32'h0080_0000; u_sz[7] = 0; u_asid[7] = 1; u_sh[7] = 0;
      for (int j = 0; j < 8; j++) u_ppn[j] = 19'($urandom);
      for (int i = 0; i < 4; i++) m_v[i] = 0;
      m_lru = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lru_bits == 6'd0, "R1 lru reset", lru_bits, 0);
      chk(req_ready && !refill_req && !res_valid, "R1 idle outputs",
          {req_ready, refill_req, res_valid}, 3'b100);

      // R9: cold miss fills slot 3, then hit on it (R2)
      fetch(32'h0000_0040, 1, 0, 0);
      fetch(32'h0000_0ABC, 1, 0, 0);
      // R7: nothing maps this address
      fetch(32'h0200_0000, 9, 0, 0);
      // R3: asid 5 gets the 1 MiB page into the next victim
      fetch(32'h0000_0040, 5, 0, 0);
      // R3/R4: privileged single-space bypass sees both pages
      fetch(32'h0000_0040, 7, 1, 1);
      // R3: privileged without single-space still compares identifiers
      fetch(32'h0000_0040, 5, 1, 0);
      // R3: shared entry matches a foreign identifier
      fetch(32'h0001_2345, 9, 0, 0);

      for (int n = 0; n < 400; n++) begin
         int j;
         logic [31:0] va;
         j = $urandom % 8;
         va = u_base[j] + ($urandom % pg_bytes(u_sz[j]));
         if ($urandom % 8 == 0) va = {$urandom} & 32'h00FF_FFFF;
         case ($urandom % 4)
            0: fetch(va, 1, 1'($urandom), 1'($urandom));
            1: fetch(va, 2, 1'($urandom), 1'($urandom));
            2: fetch(va, 5, 1'($urandom), 1'($urandom));
            default: fetch(va, u_asid[j], 0, 0);
         endcase
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule